// File: doc/BRIEF.md
# Two-Bit Serial Mealy Machine

This block is a small clocked Mealy machine. It reads one serial bit per clock and produces one output bit. Two state bits, called A and B here, hold its history. Fixed Boolean equations give the next state. The output is a combinational function of the registered state and the live input. This means the output reacts to the input within the same cycle, with no wait for a clock edge.

The block is built to be dropped into a larger design where a bit stream must be classified on the fly. The present state is driven out so that neighbouring logic, or a checker, can watch the machine's progress. State bit A is `state_o[1]` and state bit B is `state_o[0]`.

Top module: `mealy_ab_fsm`

## Requirements
- R1: While `rst_ni` is low, the state is forced to 00 without waiting for a clock edge. It stays 00 for as long as `rst_ni` is low.
- R2: At each rising edge of `clk_i`, the next value of A (`state_o[1]`) is (A AND x) OR (B AND x), taken from the values just before the edge.
- R3: At each rising edge, the next value of B (`state_o[0]`) is (NOT A) AND x.
- R4: `y_o` equals (A OR B) AND (NOT x) in the same cycle, with no clock delay. It is 0 in state 00 and 1 in states 01, 10 and 11 while x is 0.
- R5: When x is 0 at a rising edge, the state becomes 00 from every state.
- R6: When x is 1 at a rising edge, the state moves 00→01, 01→11, 10→10 and 11→10.
- R7: Whenever x is 1, `y_o` is 0, whatever the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the state to 00 |
| x_i | input | 1 | Serial input bit |
| y_o | output | 1 | Mealy output, combinational in state and input |
| state_o | output | 2 | Present state; bit 1 is A, bit 0 is B |

## Verification
The bound checker watches every clock edge. It checks that each state bit follows its equation from the previous cycle's state and input. It also checks that an input of 0 always returns the machine to 00, that an input of 1 keeps the output low, and that the state reads 00 at every edge where reset is held.

Some behaviour is not sampled at clock edges, so only the bench's directed scenarios can show it. One case is the output changing within a cycle as the input toggles. Another is the state clearing at the moment reset falls between edges. The bench also walks every state/input pair against its own model, and runs a long pseudo-random stream against that model.

// File: rtl/mealy_ab_pkg.sv
package mealy_ab_pkg;
  localparam int unsigned STATE_W = 2;
  localparam int unsigned A_BIT   = 1;
  localparam int unsigned B_BIT   = 0;

  typedef logic [STATE_W-1:0] state_t;

  localparam state_t ST_IDLE = 2'b00;
endpackage

// File: rtl/mealy_ab_next.sv
module mealy_ab_next
  import mealy_ab_pkg::*;
(
  input  state_t cur_i,
  input  logic   x_i,
  output state_t nxt_o
);
  logic a, b;
  assign a = cur_i[A_BIT];
  assign b = cur_i[B_BIT];

  always_comb begin
    nxt_o        = ST_IDLE;
    nxt_o[A_BIT] = (a & x_i) | (b & x_i);
    nxt_o[B_BIT] = ~a & x_i;
  end
endmodule

// File: rtl/mealy_ab_out.sv
module mealy_ab_out
  import mealy_ab_pkg::*;
(
  input  state_t cur_i,
  input  logic   x_i,
  output logic   y_o
);
  // any nonzero state with x low raises y
  assign y_o = (|cur_i) & ~x_i;
endmodule

// File: rtl/mealy_ab_reg.sv
module mealy_ab_reg
  import mealy_ab_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_t d_i,
  output state_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= ST_IDLE;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mealy_ab_fsm.sv
module mealy_ab_fsm
  import mealy_ab_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               x_i,
  output logic               y_o,
  output logic [STATE_W-1:0] state_o
);
  state_t cur_q, nxt_d;

  mealy_ab_next u_next (
    .cur_i (cur_q),
    .x_i   (x_i),
    .nxt_o (nxt_d)
  );

  mealy_ab_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt_d),
    .q_o    (cur_q)
  );

  mealy_ab_out u_out (
    .cur_i (cur_q),
    .x_i   (x_i),
    .y_o   (y_o)
  );

  assign state_o = cur_q;
endmodule

// File: rtl/mealy_ab_fsm_chk.sv
module mealy_ab_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       x_i,
  input logic       y_o,
  input logic [1:0] state_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (state_o == 2'b00);
  end

  property p_next_a;
    @(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> state_o[1] == (($past(state_o[1]) & $past(x_i)) | ($past(state_o[0]) & $past(x_i)));
  endproperty
  assert_next_a_R2: assert property (p_next_a);

  property p_next_b;
    @(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> state_o[0] == (~$past(state_o[1]) & $past(x_i));
  endproperty
  assert_next_b_R3: assert property (p_next_b);

  property p_out_zero_in;
    @(posedge clk_i) disable iff (!rst_ni)
      (!x_i && state_o != 2'b00) |-> y_o;
  endproperty
  assert_out_high_R4: assert property (p_out_zero_in);

  property p_zero_clears;
    @(posedge clk_i) disable iff (!rst_ni)
      !x_i |=> state_o == 2'b00;
  endproperty
  assert_zero_clears_R5: assert property (p_zero_clears);

  property p_one_from_01;
    @(posedge clk_i) disable iff (!rst_ni)
      (x_i && state_o == 2'b01) |=> state_o == 2'b11;
  endproperty
  assert_one_step_R6: assert property (p_one_from_01);

  property p_one_quiet;
    @(posedge clk_i) disable iff (!rst_ni)
      x_i |-> !y_o;
  endproperty
  assert_one_quiet_R7: assert property (p_one_quiet);
endmodule

bind mealy_ab_fsm mealy_ab_fsm_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .x_i     (x_i),
  .y_o     (y_o),
  .state_o (state_o)
);

// File: tb/mealy_ab_fsm_bench.sv
`timescale 1ns/1ps
module mealy_ab_fsm_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       x_i = 1'b0;
  logic       y_o;
  logic [1:0] state_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic ma = 1'b0, mb = 1'b0;

  always #10 clk_i = ~clk_i;

  mealy_ab_fsm u_mealy_ab_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_i),
    .y_o     (y_o),
    .state_o (state_o)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive x after negedge, check y mid-low-phase, clock, check state
  task automatic step(input logic x);
    logic ref_y, na, nb;
    @(negedge clk_i);
    x_i = x;
    #5;
    ref_y = (ma | mb) & ~x;
    check(x ? "R7" : "R4", {1'b0, y_o}, {1'b0, ref_y});
    na = (ma & x) | (mb & x);
    nb = ~ma & x;
    @(posedge clk_i);
    #1;
    ma = na; mb = nb;
    check("R2", {1'b0, state_o[1]}, {1'b0, ma});
    check("R3", {1'b0, state_o[0]}, {1'b0, mb});
    check(x ? "R6" : "R5", state_o, {ma, mb});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    x_i = 1'b0;
    #2;
    ma = 1'b0; mb = 1'b0;
    check("R1", state_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic goto_state(input logic [1:0] s);
    do_reset();
    // 00 -1-> 01 -1-> 11 -1-> 10
    case (s)
      2'b01: step(1'b1);
      2'b11: begin step(1'b1); step(1'b1); end
      2'b10: begin step(1'b1); step(1'b1); step(1'b1); end
      default: ;
    endcase
  endtask

  task automatic test_reset_state();
    #3;
    check("R1", state_o, 2'b00);
    check("R1", {1'b0, y_o}, 2'b00);
    rst_ni = 1'b1;
  endtask

  task automatic test_zero_input();
    for (int s = 0; s < 4; s++) begin
      goto_state(s[1:0]);
      step(1'b0);
    end
  endtask

  task automatic test_one_input();
    for (int s = 0; s < 4; s++) begin
      goto_state(s[1:0]);
      step(1'b1);
    end
    goto_state(2'b10);
    step(1'b1);
    step(1'b1);
    check("R6", state_o, 2'b10);
  endtask

  task automatic test_output_follows_x();
    goto_state(2'b11);
    @(negedge clk_i);
    x_i = 1'b0; #2;
    check("R4", {1'b0, y_o}, 2'b01);
    x_i = 1'b1; #2;
    check("R7", {1'b0, y_o}, 2'b00);
    x_i = 1'b0; #2;
    check("R4", {1'b0, y_o}, 2'b01);
    x_i = 1'b1;
    @(posedge clk_i); #1;
    ma = 1'b1; mb = 1'b0;
    check("R6", state_o, 2'b10);
  endtask

  task automatic test_async_reset();
    goto_state(2'b11);
    @(posedge clk_i); #4;
    rst_ni = 1'b0;
    #1;
    check("R1", state_o, 2'b00);
    ma = 1'b0; mb = 1'b0;
    @(posedge clk_i); #1;
    check("R1", state_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic test_random_stream();
    do_reset();
    for (int i = 0; i < 400; i++) step(1'($urandom));
  endtask

  initial begin
    test_reset_state();
    test_zero_input();
    test_one_input();
    test_output_follows_x();
    test_async_reset();
    test_random_stream();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule